// File: doc/BRIEF.md
# Radix-2 FFT Butterfly Stage with Scheduled Scaling

This block computes one radix-2 butterfly of a pipelined FFT. Each valid cycle it takes two complex samples A and B and a complex twiddle W. It forms the rotated sample W·B, rounds it back to the data width, and then produces the pair X = A + W·B and Y = A − W·B. The twiddle is a signed fixed-point value with CW−2 fraction bits, so unity is 2^(CW−2).

Scaling is set per stage. A runtime schedule word carries one bit per stage, and the `STAGE` parameter picks the bit that halves this stage's outputs. The schedule can instead be fixed by a parameter. In growth mode the output gains one bit in place of shifting, as long as the data width is still below a ceiling. Both conversions use round-half-to-even and wrap on overflow. A sticky flag records any overflow, and a sync pulse clears it. A valid bit travels alongside the data.

Top module: `bfly_stage`

## Requirements
- R1: Once valid, X = A + T and Y = A − T for each of the real and imaginary parts. Here T is W·B (real: br·wr − bi·wi, imaginary: br·wi + bi·wr) divided by 2^(CW−2) and rounded to DW bits.
- R2: The rounding of the twiddle product is round-half-to-even. Example: with CW=16, 1.5 becomes 2 and 0.5 becomes 0.
- R3: When bit `STAGE` of `shift_i` is 1, each sum and difference is halved with round-half-to-even. When that bit is 0, the full sum is kept. No other bit of `shift_i` has any effect.
- R4: With `HARD_SHIFT`=1, bit `STAGE` of `SHIFT_SCHED` chooses the halving and `shift_i` is ignored.
- R5: With `GROWTH`=1 and DW < MAX_W, the outputs are DW+1 bits wide, hold the exact sum and difference, and ignore shifting. If the ceiling has been reached, the stage uses its shift bit and keeps DW-bit outputs.
- R6: A result that does not fit its target width is wrapped: only its low bits are kept, in two's complement.
- R7: `ovf_o` sets after any valid sample overflows at either rounding point, and it stays set. It is not aligned in time with the data.
- R8: A one-cycle `sync_i` pulse clears `ovf_o` on the next clock edge.
- R9: `vld_o` follows `vld_i` after MULT_LAT + CONV_LAT + ADD_LAT + CONV_LAT cycles (5 by default), and the outputs carry the data of that same sample.
- R10: While `rst` is high, `vld_o`, `ovf_o` and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Input sample valid |
| sync_i | input | 1 | Pulse that clears the overflow flag |
| shift_i | input | SW | Runtime shift schedule, one bit per stage |
| a_re_i | input | DW | Sample A, real part |
| a_im_i | input | DW | Sample A, imaginary part |
| b_re_i | input | DW | Sample B, real part |
| b_im_i | input | DW | Sample B, imaginary part |
| w_re_i | input | CW | Twiddle, real part |
| w_im_i | input | CW | Twiddle, imaginary part |
| vld_o | output | 1 | Output valid |
| x_re_o | output | OW | A + W·B, real part |
| x_im_o | output | OW | A + W·B, imaginary part |
| y_re_o | output | OW | A − W·B, real part |
| y_im_o | output | OW | A − W·B, imaginary part |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The flag assertions assume that `sync_i` is a short pulse and that overflow events come only from valid samples. The stimulus drives sync as a one-cycle pulse, and only when no overflowing sample is in flight. The halving check assumes a conversion latency of one cycle and no overflow on that sample, so it skips wrapped results. The stimulus mixes twiddles within unit magnitude with deliberately oversized operands, so that wrap and flag behaviour are reached on purpose rather than by chance.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int ACC_W = 64;
  typedef logic signed [ACC_W-1:0] acc_t;

  // drop f fraction bits, ties go to the even neighbour
  function automatic acc_t cround(acc_t x, int f);
    acc_t q, rem, half;
    if (f <= 0) return x;
    q    = x >>> f;
    rem  = x - (q <<< f);
    half = acc_t'(1) <<< (f - 1);
    if (rem > half || (rem == half && q[0])) q = q + acc_t'(1);
    return q;
  endfunction

  // true when x is representable in w signed bits
  function automatic logic fits(acc_t x, int w);
    acc_t y;
    y = (x <<< (ACC_W - w)) >>> (ACC_W - w);
    return y == x;
  endfunction
endpackage

// File: rtl/bfly_pipe.sv
module bfly_pipe #(
  parameter int W   = 8,
  parameter int LAT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (LAT == 0) begin : g_wire
      assign q = d;
    end else begin : g_reg
      logic [W-1:0] r [LAT];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < LAT; i++) r[i] <= '0;
        end else begin
          r[0] <= d;
          for (int i = 1; i < LAT; i++) r[i] <= r[i-1];
        end
      end
      assign q = r[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/bfly_twiddle.sv
module bfly_twiddle
  import bfly_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int MULT_LAT = 2,
  parameter int CONV_LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic          sh_i,
  input  logic [DW-1:0] a_re_i,
  input  logic [DW-1:0] a_im_i,
  input  logic [DW-1:0] b_re_i,
  input  logic [DW-1:0] b_im_i,
  input  logic [CW-1:0] w_re_i,
  input  logic [CW-1:0] w_im_i,
  output logic          vld_o,
  output logic          sh_o,
  output logic [DW-1:0] a_re_o,
  output logic [DW-1:0] a_im_o,
  output logic [DW-1:0] t_re_o,
  output logic [DW-1:0] t_im_o,
  output logic          evt_o
);
  localparam int PW  = DW + CW + 1;
  localparam int FR  = CW - 2;
  localparam int P1W = 2 + 2*DW + 2*PW;
  localparam int P2W = 3 + 4*DW;

  logic signed [PW-1:0] p_re, p_im;
  always_comb begin
    p_re = PW'($signed(b_re_i)) * PW'($signed(w_re_i)) - PW'($signed(b_im_i)) * PW'($signed(w_im_i));
    p_im = PW'($signed(b_re_i)) * PW'($signed(w_im_i)) + PW'($signed(b_im_i)) * PW'($signed(w_re_i));
  end

  logic [P1W-1:0] m_q;
  logic           m_vld, m_sh;
  logic [DW-1:0]  m_a_re, m_a_im;
  logic [PW-1:0]  m_p_re, m_p_im;

  bfly_pipe #(.W(P1W), .LAT(MULT_LAT)) u_mul (
    .clk(clk), .rst(rst),
    .d({vld_i, sh_i, a_re_i, a_im_i, p_re, p_im}),
    .q(m_q)
  );
  assign {m_vld, m_sh, m_a_re, m_a_im, m_p_re, m_p_im} = m_q;

  acc_t          r_re, r_im;
  logic [DW-1:0] t_re, t_im;
  logic          evt;
  always_comb begin
    r_re = cround(acc_t'($signed(m_p_re)), FR);
    r_im = cround(acc_t'($signed(m_p_im)), FR);
    t_re = r_re[DW-1:0];
    t_im = r_im[DW-1:0];
    evt  = m_vld && (!fits(r_re, DW) || !fits(r_im, DW));
  end

  logic [P2W-1:0] c_q;
  bfly_pipe #(.W(P2W), .LAT(CONV_LAT)) u_conv (
    .clk(clk), .rst(rst),
    .d({m_vld, m_sh, m_a_re, m_a_im, t_re, t_im, evt}),
    .q(c_q)
  );
  assign {vld_o, sh_o, a_re_o, a_im_o, t_re_o, t_im_o, evt_o} = c_q;
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub
  import bfly_pkg::*;
#(
  parameter int DW       = 16,
  parameter int OW       = 16,
  parameter bit GROW     = 1'b0,
  parameter int ADD_LAT  = 1,
  parameter int CONV_LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic          sh_i,
  input  logic [DW-1:0] a_re_i,
  input  logic [DW-1:0] a_im_i,
  input  logic [DW-1:0] t_re_i,
  input  logic [DW-1:0] t_im_i,
  output logic          vld_o,
  output logic [OW-1:0] x_re_o,
  output logic [OW-1:0] x_im_o,
  output logic [OW-1:0] y_re_o,
  output logic [OW-1:0] y_im_o,
  output logic          evt_o
);
  localparam int SW_ = DW + 1;
  localparam int P1W = 2 + 4*SW_;
  localparam int P2W = 3 + 4*OW;

  logic signed [SW_-1:0] s_re, s_im, d_re, d_im;
  always_comb begin
    s_re = SW_'($signed(a_re_i)) + SW_'($signed(t_re_i));
    s_im = SW_'($signed(a_im_i)) + SW_'($signed(t_im_i));
    d_re = SW_'($signed(a_re_i)) - SW_'($signed(t_re_i));
    d_im = SW_'($signed(a_im_i)) - SW_'($signed(t_im_i));
  end

  logic [P1W-1:0]  a_q;
  logic            a_vld, a_sh;
  logic [SW_-1:0]  s_re_d, s_im_d, d_re_d, d_im_d;
  bfly_pipe #(.W(P1W), .LAT(ADD_LAT)) u_add (
    .clk(clk), .rst(rst),
    .d({vld_i, sh_i, s_re, s_im, d_re, d_im}),
    .q(a_q)
  );
  assign {a_vld, a_sh, s_re_d, s_im_d, d_re_d, d_im_d} = a_q;

  logic [SW_-1:0] sv [4];
  logic [OW-1:0]  ov [4];
  logic [3:0]     of;
  acc_t           v;
  always_comb begin
    sv[0] = s_re_d; sv[1] = s_im_d; sv[2] = d_re_d; sv[3] = d_im_d;
    v = '0;
    for (int k = 0; k < 4; k++) begin
      if (GROW) begin
        ov[k] = OW'(sv[k]);
        of[k] = 1'b0;
      end else begin
        v     = a_sh ? cround(acc_t'($signed(sv[k])), 1) : acc_t'($signed(sv[k]));
        ov[k] = v[OW-1:0];
        of[k] = !fits(v, OW);
      end
    end
  end

  logic [P2W-1:0] c_q;
  logic           c_sh;
  bfly_pipe #(.W(P2W), .LAT(CONV_LAT)) u_conv (
    .clk(clk), .rst(rst),
    .d({a_vld, a_sh, ov[0], ov[1], ov[2], ov[3], a_vld && (|of)}),
    .q(c_q)
  );
  assign {vld_o, c_sh, x_re_o, x_im_o, y_re_o, y_im_o, evt_o} = c_q;

  generate
    if (!GROW && CONV_LAT == 1) begin : g_chk
      // halved output is within half an LSB of the exact sum
      assert_half_close_R3: assert property (@(posedge clk) disable iff (rst)
        (vld_o && c_sh && !evt_o) |->
          ((2 * $signed(x_re_o) - $past($signed(s_re_d))) inside {-1, 0, 1}));
    end
  endgenerate
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage #(
  parameter int          DW          = 16,
  parameter int          CW          = 16,
  parameter int          SW          = 8,
  parameter int          STAGE       = 0,
  parameter bit          GROWTH      = 1'b0,
  parameter int          MAX_W       = 24,
  parameter bit          HARD_SHIFT  = 1'b0,
  parameter logic [SW-1:0] SHIFT_SCHED = '0,
  parameter int          MULT_LAT    = 2,
  parameter int          ADD_LAT     = 1,
  parameter int          CONV_LAT    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic          sync_i,
  input  logic [SW-1:0] shift_i,
  input  logic [DW-1:0] a_re_i,
  input  logic [DW-1:0] a_im_i,
  input  logic [DW-1:0] b_re_i,
  input  logic [DW-1:0] b_im_i,
  input  logic [CW-1:0] w_re_i,
  input  logic [CW-1:0] w_im_i,
  output logic          vld_o,
  output logic [DW-((GROWTH && DW < MAX_W) ? 0 : 1):0] x_re_o,
  output logic [DW-((GROWTH && DW < MAX_W) ? 0 : 1):0] x_im_o,
  output logic [DW-((GROWTH && DW < MAX_W) ? 0 : 1):0] y_re_o,
  output logic [DW-((GROWTH && DW < MAX_W) ? 0 : 1):0] y_im_o,
  output logic          ovf_o
);
  localparam bit GROW = GROWTH && (DW < MAX_W);
  localparam int OW   = GROW ? DW + 1 : DW;

  logic [SW-1:0] sh_vec;
  logic          sh_bit;
  assign sh_vec = HARD_SHIFT ? SHIFT_SCHED : shift_i;
  assign sh_bit = |(sh_vec & (SW'(1) << STAGE));

  logic          t_vld, t_sh, tw_evt, as_evt;
  logic [DW-1:0] t_a_re, t_a_im, t_re, t_im;

  bfly_twiddle #(.DW(DW), .CW(CW), .MULT_LAT(MULT_LAT), .CONV_LAT(CONV_LAT)) u_tw (
    .clk(clk), .rst(rst), .vld_i(vld_i), .sh_i(sh_bit),
    .a_re_i(a_re_i), .a_im_i(a_im_i), .b_re_i(b_re_i), .b_im_i(b_im_i),
    .w_re_i(w_re_i), .w_im_i(w_im_i),
    .vld_o(t_vld), .sh_o(t_sh), .a_re_o(t_a_re), .a_im_o(t_a_im),
    .t_re_o(t_re), .t_im_o(t_im), .evt_o(tw_evt)
  );

  bfly_addsub #(.DW(DW), .OW(OW), .GROW(GROW), .ADD_LAT(ADD_LAT), .CONV_LAT(CONV_LAT)) u_as (
    .clk(clk), .rst(rst), .vld_i(t_vld), .sh_i(t_sh),
    .a_re_i(t_a_re), .a_im_i(t_a_im), .t_re_i(t_re), .t_im_i(t_im),
    .vld_o(vld_o), .x_re_o(x_re_o), .x_im_o(x_im_o),
    .y_re_o(y_re_o), .y_im_o(y_im_o), .evt_o(as_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf_o <= 1'b0;
    else     ovf_o <= (ovf_o & ~sync_i) | tw_evt | as_evt;
  end

  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !sync_i) |=> ovf_o);
  assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> $past(tw_evt || as_evt));
  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (sync_i && !tw_evt && !as_evt) |=> !ovf_o);
endmodule

// File: tb/tb_bfly_stage.sv
module tb_bfly_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // a_re a_im b_re b_im w_re w_im shift
  localparam int VEC [NV][7] = '{
    '{100, -50, 20, 30, 16384, 0, 0},
    '{100, -50, 20, 30, 16384, 0, 1},
    '{-1200, 800, 700, -300, 11585, -11585, 0},
    '{-1200, 800, 700, -300, 11585, -11585, 1},
    '{5, -7, 3, 3, 0, 16384, 1},
    '{20000, -20000, 15000, 12000, -16384, 0, 0},
    '{-32768, 32767, -32768, 32767, 8192, 8192, 1},
    '{1, 1, 1, 1, -8192, 8192, 1}
  };

  logic clk = 0, rst = 1, vld_i = 0, sync_i = 0;
  logic [7:0]  shift_i = 0;
  logic [15:0] a_re = 0, a_im = 0, b_re = 0, b_im = 0, w_re = 0, w_im = 0;
  logic        vld_o, vld_h, vld_g, ovf_o, ovf_h, ovf_g;
  logic [15:0] x_re, x_im, y_re, y_im, hx_re, hx_im, hy_re, hy_im;
  logic [16:0] gx_re, gx_im, gy_re, gy_im;

  int total = 0, bad = 0;
  bit exp_ovf = 0;
  bit finished = 0;
  longint ex[4], eh[4], eg[4];
  bit     eof;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfly_stage #(.STAGE(2)) dut (
    .clk(clk), .rst(rst), .vld_i(vld_i), .sync_i(sync_i), .shift_i(shift_i),
    .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im), .w_re_i(w_re), .w_im_i(w_im),
    .vld_o(vld_o), .x_re_o(x_re), .x_im_o(x_im), .y_re_o(y_re), .y_im_o(y_im), .ovf_o(ovf_o));

  bfly_stage #(.STAGE(2), .GROWTH(1'b1), .MAX_W(16), .HARD_SHIFT(1'b1), .SHIFT_SCHED(8'h04)) dut_hs (
    .clk(clk), .rst(rst), .vld_i(vld_i), .sync_i(sync_i), .shift_i(shift_i),
    .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im), .w_re_i(w_re), .w_im_i(w_im),
    .vld_o(vld_h), .x_re_o(hx_re), .x_im_o(hx_im), .y_re_o(hy_re), .y_im_o(hy_im), .ovf_o(ovf_h));

  bfly_stage #(.STAGE(2), .GROWTH(1'b1), .MAX_W(20)) dut_gr (
    .clk(clk), .rst(rst), .vld_i(vld_i), .sync_i(sync_i), .shift_i(shift_i),
    .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im), .w_re_i(w_re), .w_im_i(w_im),
    .vld_o(vld_g), .x_re_o(gx_re), .x_im_o(gx_im), .y_re_o(gy_re), .y_im_o(gy_im), .ovf_o(ovf_g));

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint half_even(longint v, int f);
    longint p, q, r;
    if (f == 0) return v;
    p = longint'(1) << f;
    q = (v >= 0) ? v / p : -((-v + p - 1) / p);
    r = v - q * p;
    if (2 * r > p || (2 * r == p && (q % 2 != 0))) q = q + 1;
    return q;
  endfunction

  function automatic longint wrapw(longint v, int w);
    longint m, r;
    m = longint'(1) << w;
    r = ((v % m) + m) % m;
    if (r >= m / 2) r = r - m;
    return r;
  endfunction

  // reference: ex = default stage, eh = fixed-shift stage, eg = growth stage
  task automatic model(longint ar, longint ai, longint br, longint bi,
                       longint wr, longint wi, bit sh);
    longint tr, ti, s[4], v;
    tr = half_even(br * wr - bi * wi, 14);
    ti = half_even(br * wi + bi * wr, 14);
    eof = (wrapw(tr, 16) != tr) || (wrapw(ti, 16) != ti);
    tr = wrapw(tr, 16);
    ti = wrapw(ti, 16);
    s[0] = ar + tr; s[1] = ai + ti; s[2] = ar - tr; s[3] = ai - ti;
    for (int k = 0; k < 4; k++) begin
      eg[k] = s[k];
      v = sh ? half_even(s[k], 1) : s[k];
      if (wrapw(v, 16) != v) eof = 1;
      ex[k] = wrapw(v, 16);
      eh[k] = wrapw(half_even(s[k], 1), 16);
    end
  endtask

  task automatic run_vec(int ar, int ai, int br, int bi, int wr, int wi, bit sh);
    model(ar, ai, br, bi, wr, wi, sh);
    @(negedge clk);
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
    w_re = 16'(wr); w_im = 16'(wi);
    shift_i = sh ? 8'h05 : 8'hFB;   // only bit 2 may matter
    vld_i = 1;
    @(negedge clk);
    vld_i = 0;
    repeat (3) @(negedge clk);
    chk("R9 early vld", vld_o, 0);
    @(negedge clk);
    chk("R9 vld", vld_o, 1);
    chk("R1 x_re", $signed(x_re), ex[0]);
    chk("R1 x_im", $signed(x_im), ex[1]);
    chk("R1 y_re", $signed(y_re), ex[2]);
    chk("R1 y_im", $signed(y_im), ex[3]);
    chk("R4 hard x_re", $signed(hx_re), eh[0]);
    chk("R4 hard y_im", $signed(hy_im), eh[3]);
    chk("R5 grow x_re", $signed(gx_re), eg[0]);
    chk("R5 grow y_im", $signed(gy_im), eg[3]);
    exp_ovf = exp_ovf | eof;
    @(negedge clk);
    chk("R9 vld drop", vld_o, 0);
    chk("R7 flag", ovf_o, exp_ovf);
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync_i = 1;
    @(negedge clk);
    sync_i = 0;
    exp_ovf = 0;
    chk("R8 cleared", ovf_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a_re = 16'h1234; b_re = 16'h4321; w_re = 16'h2000; vld_i = 1; sync_i = 1;
    repeat (8) @(negedge clk);
    chk("R10 vld", vld_o, 0);
    chk("R10 ovf", ovf_o, 0);
    chk("R10 x_re", x_re, 0);
    chk("R10 y_im", y_im, 0);
    chk("R10 grow x", gx_re, 0);
    vld_i = 0; sync_i = 0;
    @(negedge clk);
    rst = 0;

    for (int i = 0; i < NV; i++)
      run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6] != 0);
    pulse_sync();

    // R1 hand values, unity twiddle
    run_vec(100, -50, 20, 30, 16384, 0, 0);
    chk("R1 hand x_re", $signed(x_re), 120);
    chk("R1 hand x_im", $signed(x_im), -20);
    chk("R1 hand y_re", $signed(y_re), 80);
    chk("R1 hand y_im", $signed(y_im), -80);

    // R2 twiddle ties: 1.5 -> 2, 0.5 -> 0
    run_vec(0, 0, 3, 1, 8192, 0, 0);
    chk("R2 tie up", $signed(x_re), 2);
    chk("R2 tie down", $signed(x_im), 0);
    chk("R2 tie neg", $signed(y_re), -2);

    // R3 halving ties: 1.5 -> 2, 2.5 -> 2; off keeps full value
    run_vec(3, 5, 0, 0, 0, 0, 1);
    chk("R3 half 3", $signed(x_re), 2);
    chk("R3 half 5", $signed(x_im), 2);
    run_vec(3, 5, 0, 0, 0, 0, 0);
    chk("R3 no shift", $signed(x_im), 5);
    chk("R4 ignores shift_i", $signed(hx_im), 2);

    // R6 wrap and R7 flag, R5 growth keeps exact sum
    chk("R7 flag clear before", ovf_o, 0);
    run_vec(32767, 0, 32767, 0, 16384, 0, 0);
    chk("R6 wrap", $signed(x_re), -2);
    chk("R6 diff", $signed(y_re), 0);
    chk("R5 grow exact", $signed(gx_re), 65534);
    chk("R5 ceiling shifts", $signed(hx_re), 32767);
    chk("R7 flag set", ovf_o, 1);
    repeat (5) @(negedge clk);
    chk("R7 sticky", ovf_o, 1);
    pulse_sync();
    run_vec(32767, 0, 32767, 0, 16384, 0, 1);
    chk("R3 shift avoids wrap", $signed(x_re), 32767);
    chk("R7 no flag", ovf_o, 0);

    // R1 random mix
    for (int i = 0; i < 40; i++) begin
      int wr, wi;
      wr = int'($urandom_range(32768, 0)) - 16384;
      wi = int'($urandom_range(32768, 0)) - 16384;
      run_vec(int'($urandom_range(65535, 0)) - 32768, int'($urandom_range(65535, 0)) - 32768,
              int'($urandom_range(65535, 0)) - 32768, int'($urandom_range(65535, 0)) - 32768,
              wr, wi, (i % 2) == 1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule